// File: doc/BRIEF.md
# Infrared Raw Symbol Capture Controller

This block watches the output of a demodulated infrared receiver and turns the waveform into a stream of measured symbols. A symbol is an active phase followed by an idle phase. Both phases are timed in 10 µs units that are derived from the core clock through a programmable prescaler. Each complete symbol is packed into one 32-bit word and stored in a receive FIFO. Software drains the FIFO through a small register interface. The decoding of any particular remote-control protocol is left to software.

A symbol ends when the next active edge arrives. A symbol also ends when its idle phase grows until the combined width reaches a programmed maximum. That second case marks the end of a transmission and raises a timeout. Three interrupt sources exist, each with its own mask: symbols received, timeout and FIFO overflow. When the FIFO overflows, it keeps what it holds. Software must drain it with reads.

The register interface has no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` follows `reg_addr` in the same cycle. A read of the data word with `reg_rd` high pops one entry at that edge. Word addresses on `reg_addr`: 0 enable, 1 config, 2 busy, 3 count, 4 data, 5 mask, 6 status, 7 clear, 8 start.

Top module: `ir_symbol_capture`

## Requirements
- R1: After reset, the config register reads 0x3E800080, and busy, count and status read 0. All three interrupt sources are masked, so `irq` is 0.
- R2: Writing 1 to bit 0 of the enable register makes busy read nonzero for BUSY_CYCLES cycles. Config writes and start writes made while busy is nonzero are ignored.
- R3: Edges are measured only after a write to the start register made while enabled and not busy, and only while config bit 7 (raw mode) is 1. At any other time the input is ignored and the count stays unchanged.
- R4: Config fields are laid out as follows: prescale in [6:0], raw mode in bit 7, FIFO level in [13:8], format in [15:14] and maximum width in [31:16]. One unit is 10*(prescale+1) clock cycles. With format 0, a symbol starts at a rising edge. The word holds the high-phase width in [15:0] and the low-phase width in [31:16]. A phase that lasts N cycles counts floor((N-1)/unit).
- R5: With format 1, the polarity is inverted. A symbol starts at a falling edge, the low phase fills [15:0] and the high phase fills [31:16].
- R6: The idle phase counts until pulse+space reaches the maximum width. The symbol is then stored with space = maximum - pulse, the timeout status is set, and capture waits for a new start edge.
- R7: The count register returns the number of stored words. A data read returns the oldest word and removes it. A data read on an empty FIFO returns 0 and changes nothing.
- R8: The symbol-received status is set by any store that finds at least (level field) words already stored.
- R9: A store into a full FIFO (DEPTH words) is dropped and sets the overflow status. The stored words are kept in order.
- R10: The status register shows the raw received, timeout and overflow flags in bits 24, 25 and 26, and the same flags ANDed with the inverted mask in bits 8, 9 and 10. Mask bits 0, 1 and 2 mask each source; writing 0 to a bit enables that source. `irq` is the OR of the masked flags.
- R11: Writing a 1 to clear-register bit 16, 17 or 18 clears the received, timeout or overflow flag. A store event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated receiver output, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data address) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| irq | output | 1 | Interrupt request, OR of unmasked flags |

## Verification
A phase counter or prescaler that slips by a count produces a word off by one unit. It also produces a timeout word whose space field differs from maximum minus pulse, and the next data read shows it. A FIFO pointer fault shows at the ports as a wrong count or as words popped out of order. In the overflow test this is caught within one drain of the full FIFO. A status flag that is set or cleared on the wrong event shows in the status register, and on `irq`, at the first read after the store or clear that caused it.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam logic [3:0] RA_ENABLE = 4'd0;
  localparam logic [3:0] RA_CONFIG = 4'd1;
  localparam logic [3:0] RA_BUSY   = 4'd2;
  localparam logic [3:0] RA_COUNT  = 4'd3;
  localparam logic [3:0] RA_DATA   = 4'd4;
  localparam logic [3:0] RA_MASK   = 4'd5;
  localparam logic [3:0] RA_STATUS = 4'd6;
  localparam logic [3:0] RA_CLEAR  = 4'd7;
  localparam logic [3:0] RA_START  = 4'd8;

  localparam int WIDTH_BITS = 16;
  localparam int WORD_BITS  = 2 * WIDTH_BITS;
  localparam int DIV_BITS   = 7;
  localparam int UNIT_TICKS = 10;

  localparam logic [31:0] CFG_RESET = 32'h3E80_0080;

  localparam int SB_RCV = 0;
  localparam int SB_TMO = 1;
  localparam int SB_OVF = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_PULSE, PH_SPACE} phase_e;
endpackage

// File: rtl/irc_tick.sv
module irc_tick import irc_pkg::*; #(
  parameter int PW = DIV_BITS,
  parameter int UNITS = UNIT_TICKS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [PW-1:0] div,
  output logic          unit
);
  localparam int DW = $clog2(UNITS);
  localparam logic [DW-1:0] DEC_LAST = DW'(UNITS - 1);

  logic [PW-1:0] pre_q;
  logic [DW-1:0] dec_q;
  logic          us_tick;

  assign us_tick = (pre_q == div);
  assign unit    = us_tick && (dec_q == DEC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      dec_q <= '0;
    end else if (clr) begin
      pre_q <= '0;
      dec_q <= '0;
    end else if (us_tick) begin
      pre_q <= '0;
      dec_q <= (dec_q == DEC_LAST) ? '0 : dec_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/irc_meter.sv
module irc_meter import irc_pkg::*; #(
  parameter int CW = WIDTH_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          pol,
  input  logic          ir_raw,
  input  logic [CW-1:0] max_w,
  input  logic          unit,
  output logic          tick_clr,
  output logic          push,
  output logic [2*CW-1:0] word,
  output logic          tmo
);
  localparam logic [CW-1:0] SAT = '1;

  logic [1:0]    sync_q;
  logic          lvl_q;
  logic          act_now, act_was, rise, fall, hit;
  logic [CW:0]   total;
  logic [CW-1:0] p_w, s_w;
  phase_e        ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ir_raw};
      lvl_q  <= sync_q[1];
    end
  end

  assign act_now = sync_q[1] ^ pol;
  assign act_was = lvl_q ^ pol;
  assign rise    = act_now && !act_was;
  assign fall    = !act_now && act_was;
  assign total   = {1'b0, p_w} + {1'b0, s_w};
  assign hit     = total >= {1'b0, max_w};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      p_w  <= '0;
      s_w  <= '0;
    end else if (!run) begin
      ph_q <= PH_IDLE;
      p_w  <= '0;
      s_w  <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (rise) begin
          ph_q <= PH_PULSE;
          p_w  <= '0;
          s_w  <= '0;
        end
        PH_PULSE: if (fall) begin
          ph_q <= PH_SPACE;
          s_w  <= '0;
        end else if (unit && p_w != SAT) begin
          p_w <= p_w + 1'b1;
        end
        PH_SPACE: if (rise) begin
          ph_q <= PH_PULSE;
          p_w  <= '0;
          s_w  <= '0;
        end else if (hit) begin
          ph_q <= PH_IDLE;
        end else if (unit && s_w != SAT) begin
          s_w <= s_w + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign push     = run && (ph_q == PH_SPACE) && (rise || hit);
  assign tmo      = run && (ph_q == PH_SPACE) && !rise && hit;
  assign word     = {s_w, p_w};
  assign tick_clr = !run || (ph_q == PH_IDLE) || rise || fall;
endmodule

// File: rtl/irc_fifo.sv
module irc_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (fill != CNTW'(DEPTH));
  assign out_valid = (fill != '0);
  assign out_data  = mem[rp_q];
  assign do_wr     = in_valid && in_ready;
  assign do_rd     = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      fill <= '0;
    end else begin
      if (do_wr) wp_q <= step(wp_q);
      if (do_rd) rp_q <= step(rp_q);
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/ir_symbol_capture.sv
module ir_symbol_capture import irc_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int BUSY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int BW   = $clog2(BUSY_CYCLES + 1);

  logic          en_q, running_q;
  logic [BW-1:0] busy_cnt;
  logic [31:0]   cfg_q;
  logic [2:0]    mask_q, sts, sts_set, sts_clr;
  logic          run, unit, tick_clr, push, tmo_evt, in_ready;
  logic          pop, out_valid;
  logic [WORD_BITS-1:0] word, out_data;
  logic [CNTW-1:0] fill;
  logic          wr_cfg, wr_start;

  assign run      = running_q && cfg_q[7];
  assign wr_cfg   = reg_wr && reg_addr == RA_CONFIG && busy_cnt == '0;
  assign wr_start = reg_wr && reg_addr == RA_START && busy_cnt == '0 && en_q;
  assign pop      = reg_rd && reg_addr == RA_DATA;

  irc_tick u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr),
    .div(cfg_q[DIV_BITS-1:0]), .unit(unit)
  );

  irc_meter u_meter (
    .clk(clk), .rst_n(rst_n), .run(run), .pol(cfg_q[15:14] == 2'b01),
    .ir_raw(ir_in), .max_w(cfg_q[31:16]), .unit(unit),
    .tick_clr(tick_clr), .push(push), .word(word), .tmo(tmo_evt)
  );

  irc_fifo #(.W(WORD_BITS), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(push), .in_ready(in_ready), .in_data(word),
    .out_valid(out_valid), .out_ready(pop), .out_data(out_data),
    .fill(fill)
  );

  always_comb begin
    sts_set = '0;
    sts_set[SB_RCV] = push && in_ready && (32'(fill) >= 32'(cfg_q[13:8]));
    sts_set[SB_TMO] = tmo_evt;
    sts_set[SB_OVF] = push && !in_ready;
    sts_clr = (reg_wr && reg_addr == RA_CLEAR) ? reg_wdata[18:16] : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      running_q <= 1'b0;
      busy_cnt  <= '0;
      cfg_q     <= CFG_RESET;
      mask_q    <= 3'b111;
      sts       <= '0;
    end else begin
      sts <= (sts & ~sts_clr) | sts_set;
      if (reg_wr && reg_addr == RA_ENABLE) begin
        en_q <= reg_wdata[0];
        busy_cnt <= reg_wdata[0] ? BW'(BUSY_CYCLES) : '0;
        if (!reg_wdata[0]) running_q <= 1'b0;
      end else if (busy_cnt != '0) begin
        busy_cnt <= busy_cnt - 1'b1;
      end
      if (wr_cfg) cfg_q <= reg_wdata;
      if (wr_start) running_q <= 1'b1;
      if (reg_wr && reg_addr == RA_MASK) mask_q <= reg_wdata[2:0];
    end
  end

  always_comb begin
    case (reg_addr)
      RA_ENABLE: reg_rdata = {31'b0, en_q};
      RA_CONFIG: reg_rdata = cfg_q;
      RA_BUSY:   reg_rdata = 32'(busy_cnt);
      RA_COUNT:  reg_rdata = 32'(fill);
      RA_DATA:   reg_rdata = out_valid ? out_data : 32'b0;
      RA_MASK:   reg_rdata = {29'b0, mask_q};
      RA_STATUS: reg_rdata = {5'b0, sts, 13'b0, sts & ~mask_q, 8'b0};
      default:   reg_rdata = 32'b0;
    endcase
  end

  assign irq = |(sts & ~mask_q);
endmodule

// File: rtl/irc_checker.sv
module irc_checker #(
  parameter int DEPTH = 64,
  parameter int CNTW = 7,
  parameter int BW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [3:0]      reg_addr,
  input logic [31:0]     reg_wdata,
  input logic [BW-1:0]   busy_cnt,
  input logic            push,
  input logic            in_ready,
  input logic            pop,
  input logic [CNTW-1:0] fill,
  input logic [2:0]      sts,
  input logic            tmo_evt
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNTW'(DEPTH)); // R7

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !in_ready) |=> sts[2]); // R9

  AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !in_ready && !pop) |=> fill == CNTW'(DEPTH)); // R9

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd0 && reg_wdata[0]) |=> busy_cnt != '0); // R2

  AST_TMO_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd7 && reg_wdata[17] && !tmo_evt) |=> !sts[1]); // R11
endmodule

bind ir_symbol_capture irc_checker #(.DEPTH(DEPTH), .CNTW(CNTW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy_cnt(busy_cnt), .push(push),
  .in_ready(in_ready), .pop(pop), .fill(fill), .sts(sts), .tmo_evt(tmo_evt)
);

// File: tb/ir_symbol_capture_bench.sv
module ir_symbol_capture_bench;
  import irc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_in = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  ir_symbol_capture u_ir_symbol_capture (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic hold(input logic lv, input int n);
    ir_in = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(RA_CONFIG, v); chk("R1 config", v, 32'h3E80_0080);
    rd(RA_BUSY, v);   chk("R1 busy", v, 0);
    rd(RA_COUNT, v);  chk("R1 count", v, 0);
    rd(RA_STATUS, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr(RA_ENABLE, 1);
    rd(RA_BUSY, v); chk("R2 busy nonzero", {31'b0, v != 0}, 1);
    wr(RA_CONFIG, 32'h0014_0080);
    rd(RA_CONFIG, v); chk("R2 config ignored while busy", v, 32'h3E80_0080);
    repeat (10) @(negedge clk);
    rd(RA_BUSY, v); chk("R2 busy released", v, 0);
    wr(RA_CONFIG, 32'h0014_0080);
    rd(RA_CONFIG, v); chk("R2 config taken", v, 32'h0014_0080);
  endtask

  task automatic t_gating();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) begin hold(1, 25); hold(0, 25); end
    rd(RA_COUNT, v); chk("R3 no capture before start", v, 0);
    wr(RA_START, 1);
    wr(RA_CONFIG, 32'h0014_0000);
    for (int i = 0; i < 3; i++) begin hold(1, 25); hold(0, 25); end
    rd(RA_COUNT, v); chk("R3 no capture with raw off", v, 0);
    wr(RA_CONFIG, 32'h0014_0080);
  endtask

  task automatic t_fmt0();
    logic [31:0] v;
    wr(RA_MASK, 0);
    hold(1, 35); hold(0, 55); hold(1, 25); ir_in = 1'b0;
    rd(RA_COUNT, v);  chk("R7 count one", v, 1);
    rd(RA_STATUS, v); chk("R10 status rcv", v, 32'h0100_0100);
    chk("R10 irq on", {31'b0, irq}, 1);
    rd(RA_DATA, v);   chk("R4 word", v, 32'h0005_0003);
    repeat (300) @(negedge clk);
    rd(RA_COUNT, v);  chk("R6 count after timeout", v, 1);
    rd(RA_DATA, v);   chk("R6 timeout word", v, 32'h0012_0002);
    rd(RA_STATUS, v); chk("R6 status tmo", v, 32'h0300_0300);
    wr(RA_CLEAR, 32'h0003_0000);
    rd(RA_STATUS, v); chk("R11 cleared", v, 0);
    chk("R11 irq off", {31'b0, irq}, 0);
  endtask

  task automatic t_fmt1();
    logic [31:0] v;
    wr(RA_CONFIG, 32'h0014_4080);
    hold(1, 30); hold(0, 45); hold(1, 65); hold(0, 15); hold(1, 300);
    rd(RA_COUNT, v); chk("R5 count", v, 2);
    rd(RA_DATA, v);  chk("R5 inverted word", v, 32'h0006_0004);
    rd(RA_DATA, v);  chk("R5 inverted timeout word", v, 32'h0013_0001);
    wr(RA_CLEAR, 32'h0007_0000);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(RA_CONFIG, 32'h0014_0280);
    wr(RA_MASK, 1);
    hold(0, 30);
    hold(1, 25); hold(0, 25); hold(1, 25); hold(0, 25); hold(1, 25); ir_in = 1'b0;
    rd(RA_COUNT, v);  chk("R8 two stored", v, 2);
    rd(RA_STATUS, v); chk("R8 below level", v, 0);
    hold(1, 25); ir_in = 1'b0;
    rd(RA_STATUS, v); chk("R8 level reached, R10 masked", v, 32'h0100_0000);
    chk("R10 masked irq", {31'b0, irq}, 0);
    repeat (300) @(negedge clk);
    rd(RA_COUNT, v);  chk("R7 count four", v, 4);
    rd(RA_DATA, v);   chk("R7 fifo order 1", v, 32'h0002_0002);
    rd(RA_DATA, v);   chk("R7 fifo order 2", v, 32'h0002_0002);
    rd(RA_DATA, v);   rd(RA_DATA, v);
    wr(RA_CLEAR, 32'h0007_0000);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(RA_CONFIG, 32'h0014_3F80);
    wr(RA_MASK, 0);
    for (int i = 0; i < 66; i++) begin hold(1, 25); hold(0, 25); end
    repeat (300) @(negedge clk);
    rd(RA_COUNT, v);  chk("R9 full count", v, 64);
    rd(RA_STATUS, v); chk("R9 status ovf", v, 32'h0700_0700);
    for (int i = 0; i < 64; i++) begin
      rd(RA_DATA, v); chk("R9 kept word", v, 32'h0002_0002);
    end
    rd(RA_COUNT, v);  chk("R7 drained", v, 0);
    rd(RA_DATA, v);   chk("R7 empty read", v, 0);
    rd(RA_COUNT, v);  chk("R7 empty read no change", v, 0);
    wr(RA_CLEAR, 32'h0004_0000);
    rd(RA_STATUS, v); chk("R11 ovf only cleared", v, 32'h0300_0300);
    wr(RA_CLEAR, 32'h0003_0000);
    rd(RA_STATUS, v); chk("R11 all cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_busy();
    t_gating();
    t_fmt0();
    t_fmt1();
    t_level();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule